// File: doc/BRIEF.md
# Phase-Stepped Hardwired Instruction Sequencer

This block is the control core of a small one-address machine. A two-bit phase register chooses among fetch, indirect, execute and interrupt work. A step counter inside each phase picks the group of register transfers that runs on a given clock. The core contains its own transfer registers: a memory address register, a memory buffer, a program counter, an instruction register and one accumulator. It drives a single-port synchronous memory through one address bus, read and write strobes, and a write-data bus. The memory returns read data one clock after the strobe, so every read takes two steps: one to launch it and one to capture the result.

An instruction word has three fields. Bits [15:12] hold the opcode, bit [11] is the indirect flag and bits [10:0] hold the address. Opcode 0x1 adds a memory word to the accumulator. Opcode 0x2 increments a memory word and skips the next instruction when the result is zero. Opcode 0x3 stores the return address at X and continues at X+1. Every other opcode is a one-step no-operation.

The phases are named FETCH (code 00), INDIRECT (01), EXECUTE (10) and INTERRUPT (11). The transitions are:
- FETCH to INDIRECT when the indirect flag is set, otherwise FETCH to EXECUTE.
- INDIRECT always goes to EXECUTE.
- EXECUTE goes to INTERRUPT when a request is pending and enabled, otherwise EXECUTE goes to FETCH.
- INTERRUPT always goes to FETCH.

Each phase ends on its last step, and the step counter then returns to zero.

Top module: `mcu_core`

## Requirements
- R1: While synchronous active-high reset is held, the program counter is 0, the phase code is 00, the accumulator is 0, and neither memory strobe is active.
- R2: FETCH takes four clocks. Step 0 copies the program counter into the address register. Step 1 raises the read strobe on that address and advances the program counter by one. Step 2 captures the read data into the buffer. Step 3 copies the buffer into the instruction register.
- R3: The phase code on `phase_q` uses 00 FETCH, 01 INDIRECT, 10 EXECUTE and 11 INTERRUPT. The only legal transitions are FETCH to INDIRECT or EXECUTE, INDIRECT to EXECUTE, EXECUTE to FETCH or INTERRUPT, and INTERRUPT to FETCH.
- R4: INDIRECT takes four clocks. It reads the word at the address field and replaces the instruction's address field (bits [10:0]) with that word's low 11 bits. The indirect flag stays 1 throughout the phase.
- R5: Opcode 0x1 runs in four execute clocks and leaves the accumulator at accumulator + mem[address], modulo 2^16.
- R6: Opcode 0x2 runs in five execute clocks and writes mem[address]+1 back to the same address. In that same write clock it adds one more to the program counter when the written value is zero.
- R7: Opcode 0x3 runs in three execute clocks. It writes the address of the following instruction to X and continues execution at X+1.
- R8: Any opcode other than 0x1, 0x2 or 0x3 finishes EXECUTE in a single clock and changes no register or memory word.
- R9: INTERRUPT is entered only at the end of EXECUTE, and only when `irq_req` and `irq_en` are both high on that clock edge.
- R10: INTERRUPT takes three clocks. It writes the return address, zero-extended to 16 bits, to SAVE_ADDR (default 0x7F0) and loads the program counter with VEC_ADDR (default 0x7E0). It pulses `irq_ack` for one clock during the final write step.
- R11: Read data is captured into the buffer one clock after the read strobe. No clock both loads the buffer from memory and loads the instruction register from the buffer. Read and write strobes are never both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory address, taken from the address register |
| mem_rd | output | 1 | Read strobe; data is returned on the next clock |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| irq_req | input | 1 | Level-sensitive interrupt request |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | output | 1 | One-clock acknowledge in the interrupt phase |
| acc_q | output | 16 | Accumulator contents |
| pc_q | output | 11 | Program counter contents |
| phase_q | output | 2 | Current phase code |

## Verification
Two functions share one clock in the increment-and-skip instruction: the write-back of the incremented word and the conditional program-counter bump. The bench provokes this with operands of 0xFFFF, reached both directly and through an indirect pointer, so the result wraps to zero. It judges the result from three things: the data seen on the write bus, the skipped instruction leaving the accumulator unchanged, and the program counter landing two words past the instruction. The other overlap is the read launch with the counter increment in fetch. The bench checks it by watching the read strobe and address in step 1 and the advanced counter one clock later.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = 11;
    localparam int WORD_W = OPC_W + 1 + ADDR_W;
    localparam int IND_POS = ADDR_W;
    localparam int OPC_LSB = ADDR_W + 1;
    localparam int STEP_W = 3;

    localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
    localparam logic [OPC_W-1:0] OP_ISZ = 4'h2;
    localparam logic [OPC_W-1:0] OP_BSA = 4'h3;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_IND   = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    // one bit per register transfer the sequencer can request in a step
    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mar_save;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_inc;
        logic ir_load;
        logic ir_addr;
        logic pc_inc;
        logic pc_ir;
        logic pc_vec;
        logic pc_skipz;
        logic acc_add;
        logic rd;
        logic wr;
        logic ack;
    } ctl_t;
endpackage

// File: rtl/mcu_seq.sv
module mcu_seq
    import mcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              ind_bit,
    input  logic              irq_pend,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output ctl_t              ctl
);
    logic   last;
    phase_e nxt;

    // state register: phase code and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            step  <= '0;
        end else if (last) begin
            phase <= nxt;
            step  <= '0;
        end else begin
            step  <= step + 1'b1;
        end
    end

    // output decode: transfer group per phase and step
    always_comb begin
        ctl  = '0;
        last = 1'b0;
        unique case (phase)
            PH_FETCH: begin
                case (step)
                    3'd0:    ctl.mar_pc = 1'b1;
                    3'd1:    begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; end
                    3'd2:    ctl.mbr_mem = 1'b1;
                    default: begin ctl.ir_load = 1'b1; last = 1'b1; end
                endcase
            end
            PH_IND: begin
                case (step)
                    3'd0:    ctl.mar_ir = 1'b1;
                    3'd1:    ctl.rd = 1'b1;
                    3'd2:    ctl.mbr_mem = 1'b1;
                    default: begin ctl.ir_addr = 1'b1; last = 1'b1; end
                endcase
            end
            PH_EXEC: begin
                if (opcode == OP_ADD || opcode == OP_ISZ) begin
                    case (step)
                        3'd0: ctl.mar_ir = 1'b1;
                        3'd1: ctl.rd = 1'b1;
                        3'd2: ctl.mbr_mem = 1'b1;
                        3'd3: begin
                            if (opcode == OP_ADD) begin
                                ctl.acc_add = 1'b1;
                                last = 1'b1;
                            end else begin
                                ctl.mbr_inc = 1'b1;
                            end
                        end
                        default: begin ctl.wr = 1'b1; ctl.pc_skipz = 1'b1; last = 1'b1; end
                    endcase
                end else if (opcode == OP_BSA) begin
                    case (step)
                        3'd0:    begin ctl.mar_ir = 1'b1; ctl.mbr_pc = 1'b1; end
                        3'd1:    begin ctl.pc_ir = 1'b1; ctl.wr = 1'b1; end
                        default: begin ctl.pc_inc = 1'b1; last = 1'b1; end
                    endcase
                end else begin
                    last = 1'b1;
                end
            end
            PH_INTR: begin
                case (step)
                    3'd0:    ctl.mbr_pc = 1'b1;
                    3'd1:    begin ctl.mar_save = 1'b1; ctl.pc_vec = 1'b1; end
                    default: begin ctl.wr = 1'b1; ctl.ack = 1'b1; last = 1'b1; end
                endcase
            end
        endcase
    end

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_FETCH: nxt = ind_bit ? PH_IND : PH_EXEC;
            PH_IND:   nxt = PH_EXEC;
            PH_EXEC:  nxt = irq_pend ? PH_INTR : PH_FETCH;
            PH_INTR:  nxt = PH_FETCH;
        endcase
    end

    p_ind_to_exec_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IND && phase != PH_IND) |-> phase == PH_EXEC);
    p_intr_to_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_INTR && phase != PH_INTR) |-> phase == PH_FETCH);
    p_intr_gated_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_EXEC && phase == PH_INTR) |-> $past(irq_pend));
endmodule

// File: rtl/mcu_dp.sv
module mcu_dp
    import mcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 11'h7E0
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mbr,
    output logic [WORD_W-1:0] ir,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] acc
);
    localparam int PAD_W = WORD_W - ADDR_W;

    logic mbr_zero;
    assign mbr_zero = (mbr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            pc  <= '0;
            acc <= '0;
        end else begin
            if (ctl.mar_pc)        mar <= pc;
            else if (ctl.mar_ir)   mar <= ir[ADDR_W-1:0];
            else if (ctl.mar_save) mar <= SAVE_ADDR;

            if (ctl.mbr_mem)       mbr <= mem_rdata;
            else if (ctl.mbr_pc)   mbr <= {{PAD_W{1'b0}}, pc};
            else if (ctl.mbr_inc)  mbr <= mbr + 1'b1;

            if (ctl.ir_load)       ir <= mbr;
            else if (ctl.ir_addr)  ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];

            if (ctl.pc_vec)        pc <= VEC_ADDR;
            else if (ctl.pc_ir)    pc <= ir[ADDR_W-1:0];
            else if (ctl.pc_inc || (ctl.pc_skipz && mbr_zero))
                                   pc <= pc + 1'b1;

            if (ctl.acc_add)       acc <= acc + mbr;
        end
    end

    p_no_mbr_ir_clash_r11: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mbr_mem && (ctl.ir_load || ctl.ir_addr)));
    p_vector_load_r10: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_vec |=> pc == VEC_ADDR);
    p_noskip_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_skipz && !mbr_zero) |=> $stable(pc));
endmodule

// File: rtl/mcu_core.sv
module mcu_core
    import mcu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 11'h7E0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              irq_req,
    input  logic              irq_en,
    output logic              irq_ack,
    output logic [WORD_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [1:0]        phase_q
);
    phase_e            phase;
    logic [STEP_W-1:0] step;
    ctl_t              ctl;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;
    logic [WORD_W-1:0] ir;

    mcu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir[WORD_W-1:OPC_LSB]),
        .ind_bit  (mbr[IND_POS]),
        .irq_pend (irq_req && irq_en),
        .phase    (phase),
        .step     (step),
        .ctl      (ctl)
    );

    mcu_dp #(
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .pc        (pc_q),
        .acc       (acc_q)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign irq_ack   = ctl.ack;
    assign phase_q   = phase;

    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    p_ack_then_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> phase_q == PH_FETCH);
    p_ind_flag_held_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IND && step != '0) |-> ir[IND_POS]);
    p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> step < 3'd4);
endmodule

// File: tb/mcu_core_bench.sv
module mcu_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] mem_addr;
    logic        mem_rd, mem_wr, irq_ack;
    logic [15:0] mem_wdata, acc_q;
    logic [15:0] rdata = 16'h0;
    logic [10:0] pc_q;
    logic [1:0]  phase_q;
    logic        irq_raise = 1'b0, irq_en = 1'b0, acked = 1'b0;
    logic        irq_req;
    logic        ld_en = 1'b0;
    logic [10:0] ld_a = '0;
    logic [15:0] ld_d = '0;
    logic [15:0] mem [0:2047] = '{default: 16'h0};

    int n_cmp = 0, n_bad = 0, n_ack = 0, run = 0;
    bit done = 1'b0;
    logic [1:0] prev = 2'b00;
    logic [26:0] exp_q[$];
    string       exp_r[$];
    int          xl_q[$];
    string       xl_r[$];

    always #4 clk = ~clk;
    assign irq_req = irq_raise && !acked;

    mcu_core u_mcu_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(rdata), .irq_req(irq_req), .irq_en(irq_en),
        .irq_ack(irq_ack), .acc_q(acc_q), .pc_q(pc_q), .phase_q(phase_q)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_a] <= ld_d;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exv);
        end
    endtask

    task automatic load(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic expect_wr(input logic [10:0] a, input logic [15:0] d, input string req);
        exp_q.push_back({a, d});
        exp_r.push_back(req);
    endtask

    task automatic expect_xl(input int n, input string req);
        xl_q.push_back(n);
        xl_r.push_back(req);
    endtask

    // monitor: write scoreboard, phase run lengths, transitions
    always @(negedge clk) begin
        if (rst) begin
            run = 0; prev = 2'b00;
        end else begin
            if (mem_wr) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 R7 R10 extra write", {5'b0, mem_addr, mem_wdata}, 32'h0);
                else begin
                    logic [26:0] e;
                    string r;
                    e = exp_q.pop_front(); r = exp_r.pop_front();
                    chk({mem_addr, mem_wdata} == e, r, {5'b0, mem_addr, mem_wdata}, {5'b0, e});
                end
            end
            if (mem_rd && mem_wr) chk(1'b0, "R11 rd and wr together", 32'h1, 32'h0);
            if (irq_ack) begin n_ack++; acked = 1'b1; end
            if (phase_q == prev) run++;
            else begin
                case (prev)
                    2'b00: begin
                        chk(run == 4, "R2 fetch length", run, 4);
                        chk(phase_q == 2'b01 || phase_q == 2'b10, "R3 after fetch", phase_q, 2);
                    end
                    2'b01: begin
                        chk(run == 4, "R4 indirect length", run, 4);
                        chk(phase_q == 2'b10, "R3 after indirect", phase_q, 2);
                    end
                    2'b10: begin
                        if (xl_q.size() != 0) begin
                            int n;
                            string r;
                            n = xl_q.pop_front(); r = xl_r.pop_front();
                            chk(run == n, r, run, n);
                        end
                        chk(phase_q == 2'b00 || phase_q == 2'b11, "R3 after execute", phase_q, 0);
                    end
                    default: begin
                        chk(run == 3, "R10 interrupt length", run, 3);
                        chk(phase_q == 2'b00, "R3 after interrupt", phase_q, 0);
                    end
                endcase
                prev = phase_q;
                run = 1;
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        irq_raise = 1'b1;   // held high while disabled: must be ignored (R9)
        // program: fields [15:12] opcode, [11] indirect, [10:0] address
        load(11'h000, 16'h1040); load(11'h001, 16'h1841); load(11'h002, 16'h2043);
        load(11'h003, 16'h1040); load(11'h004, 16'h2044); load(11'h005, 16'h3050);
        load(11'h051, 16'hF000); load(11'h052, 16'h2845); load(11'h053, 16'h1040);
        load(11'h054, 16'h1047); load(11'h7E0, 16'h1040); load(11'h7E1, 16'h3060);
        load(11'h040, 16'h0005); load(11'h041, 16'h0042); load(11'h042, 16'h0007);
        load(11'h043, 16'hFFFF); load(11'h044, 16'h0003); load(11'h045, 16'h0046);
        load(11'h046, 16'hFFFF); load(11'h047, 16'h0010);

        @(negedge clk);
        chk(pc_q == 0, "R1 pc", pc_q, 0);
        chk(phase_q == 0, "R1 phase", phase_q, 0);
        chk(acc_q == 0, "R1 acc", acc_q, 0);
        chk(!mem_rd && !mem_wr, "R1 strobes", {mem_rd, mem_wr}, 0);

        expect_wr(11'h043, 16'h0000, "R6 wrap write");
        expect_wr(11'h044, 16'h0004, "R6 plain write");
        expect_wr(11'h050, 16'h0006, "R7 return addr");
        expect_wr(11'h046, 16'h0000, "R4 R6 indirect write");
        expect_wr(11'h7F0, 16'h0055, "R10 save");
        expect_wr(11'h060, 16'h07E2, "R7 return addr 2");
        expect_xl(4, "R5 R11 add len"); expect_xl(4, "R4 R5 add ind len");
        expect_xl(5, "R6 isz len"); expect_xl(5, "R6 isz len 2");
        expect_xl(3, "R7 bsa len"); expect_xl(1, "R8 nop len");
        expect_xl(5, "R6 isz ind len"); expect_xl(4, "R5 add len 3");
        expect_xl(4, "R5 R10 vector add len"); expect_xl(3, "R7 bsa len 2");
        expect_xl(1, "R8 nop len 2");

        rst = 1'b0;
        @(negedge clk);
        chk(mem_rd && mem_addr == 0, "R2 read launch", {mem_rd, mem_addr}, 32'h800);
        @(negedge clk);
        chk(pc_q == 1, "R2 pc advanced", pc_q, 1);

        while (pc_q != 11'h054) @(negedge clk);
        chk(acc_q == 16'd12, "R6 skips kept acc", acc_q, 12);
        chk(n_ack == 0, "R9 no interrupt while disabled", n_ack, 0);
        irq_en = 1'b1;

        while (exp_q.size() != 0 || xl_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(acc_q == 16'h0021, "R5 R10 final acc", acc_q, 16'h21);
        chk(n_ack == 1, "R10 single ack", n_ack, 1);
        chk(pc_q > 11'h061, "R8 nops advance", pc_q, 11'h062);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule